// File: doc/BRIEF.md
# PWM Emergency Stop Stage

This block sits between a four-channel pulse-width generator and the output pins, and drives each pin to a known safe level when a fault appears. A 12-bit free-running up-counter is compared with a per-channel 12-bit duty value to form the normal waveforms. Each duty value is written into a shadow register and moves into use only when the counter rolls over, so a period is never cut short.

A byte-wide control register selects the fault source and the polarity that counts as a fault, and gates the external fault pin. It also holds a sticky fault flag and a four-bit safe-level pattern. The source is either the external pin or a comparator result. Both inputs are resynchronised through two flops. Once the chosen source shows its active level, hardware latches the fault flag. While the flag is set, each output whose enable is high carries its pattern bit in place of the waveform. Software can set or clear the flag by writing the register. An output whose enable is low always stays low.

Top module: `pwm_break_unit`

## Requirements
- R1: The control register resets to 00h and reads back on `reg_rdata` the byte last written through `reg_wr`/`reg_wdata`. Its fields are: bit 7 source select, bit 6 level select, bit 5 fault flag, bit 4 pin enable, and bits 3:0 safe pattern, with bit i belonging to channel i.
- R2: With source select at 1, the comparator input is the fault source, whatever the value of pin enable. With source select at 0, the external pin is the source.
- R3: With source select at 0 and pin enable at 0, the external pin never sets the fault flag.
- R4: With level select at 0, a low source level is a fault. With level select at 1, a high source level is a fault.
- R5: A change of the source input to its active level, applied before clock edge k, shows as a set fault flag from edge k+2 on. The flag stays set after the source returns to inactive, until software writes 0 to bit 5.
- R6: If a hardware set and a software write of 0 to bit 5 fall on the same edge, the flag ends up set.
- R7: While the fault flag reads 1, every channel whose `out_en` bit is 1 outputs its pattern bit. This holds in the same cycle in which the flag first reads 1.
- R8: With the flag clear and `out_en` high, channel i is high exactly while the counter is below its active duty value. The counter is 0 after reset, adds 1 on every edge and wraps from 4095 to 0.
- R9: A channel whose `out_en` bit is 0 outputs 0, whether or not a fault is active.
- R10: A duty write through `duty_wr`/`duty_sel`/`duty_wdata` changes the waveform only from the counter wrap to 0 that follows it.
- R11: After reset, all outputs are low and all duty values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| duty_wr | input | 1 | Duty shadow write strobe |
| duty_sel | input | 2 | Channel addressed by a duty write |
| duty_wdata | input | 12 | Duty value to write |
| out_en | input | 4 | Per-channel output enable |
| brk_pin | input | 1 | External fault pin, asynchronous |
| cmp_in | input | 1 | Comparator result, asynchronous |
| pwm_out | output | 4 | Channel outputs after the override |

## Verification
A register write shows on `reg_rdata` right after the edge that takes it. The counter, the waveform and any duty takeover all move on the same edge, so `pwm_out` follows the counter with no extra lag. A fault input reaches the flag on the third edge after it changes, and the override reaches the pins in that same cycle. The bench drives inputs at the falling edge and updates a cycle-accurate reference model at each rising edge. It compares outputs at the next falling edge. Its directed checks on the flag are placed exactly on the second and third edges after a fault input changes.

// File: rtl/pbrk_pkg.sv
package pbrk_pkg;

    localparam int NUM_CH = 4;
    localparam int CTRL_W = 8;
    localparam int SEL_W  = $clog2(NUM_CH);

    // Field order is the register's bit order, MSB first
    typedef struct packed {
        logic              src_cmp;   // 1: comparator, 0: external pin
        logic              lvl_high;  // 1: high is a fault, 0: low is a fault
        logic              brk_flag;  // sticky fault flag
        logic              pin_en;    // gates the external pin
        logic [NUM_CH-1:0] pattern;   // safe level per channel
    } brk_ctrl_t;

    typedef struct packed {
        logic cmp;
        logic pin;
    } brk_src_t;

    function automatic logic level_hit(input logic sig, input logic lvl_high);
        return lvl_high ? sig : ~sig;
    endfunction

    function automatic logic pick_out(input logic en, input logic flag,
                                      input logic safe, input logic wave);
        return en & (flag ? safe : wave);
    endfunction

endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
    import pbrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  brk_src_t          src_s,
    output brk_ctrl_t         ctrl,
    output logic              hw_set
);
    brk_ctrl_t ctrl_q;

    always_comb begin
        if (ctrl_q.src_cmp)
            hw_set = level_hit(src_s.cmp, ctrl_q.lvl_high);
        else
            hw_set = ctrl_q.pin_en & level_hit(src_s.pin, ctrl_q.lvl_high);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (wr)
                ctrl_q <= brk_ctrl_t'(wdata);
            // a hardware set overrides a software clear on the same edge
            if (hw_set)
                ctrl_q.brk_flag <= 1'b1;
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pbrk_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 duty_wr,
    input  logic [SEL_W-1:0]     duty_sel,
    input  logic [CW-1:0]        duty_wdata,
    output logic [NUM_CH-1:0]    wave,
    output logic [CW-1:0]        cnt,
    output logic [NUM_CH*CW-1:0] duty_act_flat
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          wrap;

    assign wrap    = (cnt_q == CNT_MAX);
    assign cnt_nxt = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic [CW-1:0] shadow_q;
            logic [CW-1:0] act_q;
            logic [CW-1:0] act_nxt;
            logic          wave_q;

            assign act_nxt = wrap ? shadow_q : act_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    shadow_q <= '0;
                    act_q    <= '0;
                    wave_q   <= 1'b0;
                end else begin
                    if (duty_wr && duty_sel == SEL_W'(i))
                        shadow_q <= duty_wdata;
                    act_q  <= act_nxt;
                    wave_q <= (cnt_nxt < act_nxt);
                end
            end

            assign wave[i] = wave_q;
            assign duty_act_flat[i*CW +: CW] = act_q;
        end
    endgenerate

    assign cnt = cnt_q;
endmodule

// File: rtl/pwm_break_unit.sv
module pwm_break_unit
    import pbrk_pkg::*;
#(
    parameter int CW        = 12,
    parameter int SYNC_STG  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [CTRL_W-1:0]   reg_wdata,
    output logic [CTRL_W-1:0]   reg_rdata,
    input  logic                duty_wr,
    input  logic [SEL_W-1:0]    duty_sel,
    input  logic [CW-1:0]       duty_wdata,
    input  logic [NUM_CH-1:0]   out_en,
    input  logic                brk_pin,
    input  logic                cmp_in,
    output logic [NUM_CH-1:0]   pwm_out
);
    brk_src_t                src_raw;
    brk_src_t                src_s;
    logic [1:0]              src_s_bits;
    brk_ctrl_t               ctrl;
    logic                    hw_set;
    logic [NUM_CH-1:0]       wave;
    logic [CW-1:0]           cnt;
    logic [NUM_CH*CW-1:0]    duty_act_flat;

    assign src_raw = '{cmp: cmp_in, pin: brk_pin};

    brk_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (src_raw),
        .d_out (src_s_bits)
    );
    assign src_s = brk_src_t'(src_s_bits);

    brk_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .src_s  (src_s),
        .ctrl   (ctrl),
        .hw_set (hw_set)
    );

    pwm_core #(.CW(CW)) u_core (
        .clk           (clk),
        .rst           (rst),
        .duty_wr       (duty_wr),
        .duty_sel      (duty_sel),
        .duty_wdata    (duty_wdata),
        .wave          (wave),
        .cnt           (cnt),
        .duty_act_flat (duty_act_flat)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_out
            assign pwm_out[i] = pick_out(out_en[i], ctrl.brk_flag,
                                         ctrl.pattern[i], wave[i]);
        end
    endgenerate

    assign reg_rdata = CTRL_W'(ctrl);
endmodule

// File: rtl/pwm_break_chk.sv
module pwm_break_chk
    import pbrk_pkg::*;
#(
    parameter int CW = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [CTRL_W-1:0]    reg_rdata,
    input logic [NUM_CH-1:0]    out_en,
    input logic [NUM_CH-1:0]    pwm_out,
    input logic                 hw_set,
    input logic [CW-1:0]        cnt,
    input logic [NUM_CH*CW-1:0] duty_act
);
    assert_oe_low_R9: assert property (@(posedge clk) disable iff (rst)
        (pwm_out & ~out_en) == '0);

    assert_pattern_R7: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[5] |-> ((pwm_out ^ reg_rdata[3:0]) & out_en) == '0);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[5] && !reg_wr) |=> reg_rdata[5]);

    assert_hw_wins_R6: assert property (@(posedge clk) disable iff (rst)
        hw_set |=> reg_rdata[5]);

    assert_pin_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[7] && !reg_rdata[4] && !reg_rdata[5] && !reg_wr) |=> !reg_rdata[5]);

    assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1) |=> (cnt == '0));

    assert_duty_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt != '1) |=> $stable(duty_act));
endmodule

bind pwm_break_unit pwm_break_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .out_en    (out_en),
    .pwm_out   (pwm_out),
    .hw_set    (hw_set),
    .cnt       (cnt),
    .duty_act  (duty_act_flat)
);

// File: tb/tb_pwm_break_unit.sv
module tb_pwm_break_unit;
    localparam int CW   = 12;
    localparam int MAXC = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        duty_wr;
    logic [1:0]  duty_sel;
    logic [11:0] duty_wdata;
    logic [3:0]  out_en;
    logic        brk_pin;
    logic        cmp_in;
    logic [3:0]  pwm_out;

    always #10 clk = ~clk;

    pwm_break_unit dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .duty_wr(duty_wr), .duty_sel(duty_sel),
        .duty_wdata(duty_wdata), .out_en(out_en), .brk_pin(brk_pin),
        .cmp_in(cmp_in), .pwm_out(pwm_out)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int wd     = 0;

    // reference model state
    logic [7:0] m_reg;
    logic       p1, p2, c1, c2;
    int         m_cnt;
    int         m_sh [4];
    int         m_act[4];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic hit(input logic s, input logic hi);
        return hi ? s : ~s;
    endfunction

    task automatic model_reset();
        m_reg = 8'h00; p1 = 0; p2 = 0; c1 = 0; c2 = 0; m_cnt = 0;
        for (int i = 0; i < 4; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    endtask

    // called right after a rising edge, with the inputs that edge sampled
    task automatic model_edge();
        logic hw;
        hw = m_reg[7] ? hit(c2, m_reg[6]) : (m_reg[4] & hit(p2, m_reg[6]));
        if (reg_wr) m_reg = reg_wdata;
        if (hw) m_reg[5] = 1'b1;
        p2 = p1; p1 = brk_pin; c2 = c1; c1 = cmp_in;
        if (m_cnt == MAXC)
            for (int i = 0; i < 4; i++) m_act[i] = m_sh[i];
        if (duty_wr) m_sh[duty_sel] = duty_wdata;
        m_cnt = (m_cnt == MAXC) ? 0 : m_cnt + 1;
    endtask

    function automatic logic exp_out(input int i);
        if (!out_en[i]) return 1'b0;
        if (m_reg[5])   return m_reg[i];
        return (m_cnt < m_act[i]);
    endfunction

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R1 reg", reg_rdata, m_reg);
        for (int i = 0; i < 4; i++) begin
            if (!out_en[i])    chk("R9 out", pwm_out[i], exp_out(i));
            else if (m_reg[5]) chk("R7 out", pwm_out[i], exp_out(i));
            else               chk("R8 out", pwm_out[i], exp_out(i));
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        reg_wr = 1; reg_wdata = v; cycle(); reg_wr = 0;
    endtask

    task automatic wr_duty(input int ch, input int v);
        duty_wr = 1; duty_sel = 2'(ch); duty_wdata = 12'(v); cycle(); duty_wr = 0;
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; reg_wr = 0; reg_wdata = 0; duty_wr = 0; duty_sel = 0;
        duty_wdata = 0; out_en = 4'hF; brk_pin = 0; cmp_in = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        chk("R1 reset reg", reg_rdata, 8'h00);
        chk("R11 reset out", pwm_out, 4'h0);

        // R8 / R10: waveforms with no fault; pin low-active would fire but pin is gated (R3)
        wr_duty(0, 12'h010);
        wr_duty(1, 12'h800);
        wr_duty(2, 12'h000);
        wr_duty(3, 12'hFFF);
        for (int n = 0; n < 2 * (MAXC + 1); n++) cycle();
        chk("R3 gated pin", reg_rdata[5], 0);

        // R10: new duty waits for wrap
        while (m_cnt != 100) cycle();
        wr_duty(0, 12'h800);
        chk("R10 old duty kept", pwm_out[0], 0);
        while (m_cnt != 2) cycle();
        chk("R10 new duty at wrap", pwm_out[0], 1);

        // R5 / R4: pin source, high active, pattern 1010
        wr_reg(8'b0101_1010);
        repeat (4) cycle();
        chk("R4 inactive level", reg_rdata[5], 0);
        brk_pin = 1;
        cycle(); cycle();
        chk("R5 not yet", reg_rdata[5], 0);
        cycle();
        chk("R5 set on third edge", reg_rdata[5], 1);
        chk("R7 pattern", pwm_out, 4'b1010);
        brk_pin = 0;
        repeat (6) cycle();
        chk("R5 sticky", reg_rdata[5], 1);
        wr_reg(8'b0101_1010 & 8'hDF);
        chk("R5 sw clear", reg_rdata[5], 0);
        out_en = 4'b0011;
        wr_reg(8'b0111_0110);
        chk("R9 oe low masks pattern", pwm_out, 4'b0010);
        wr_reg(8'h00);
        out_en = 4'hF;

        // R2 / R4: comparator, low active, pin enable off
        wr_reg(8'b1000_0101);
        repeat (4) cycle();
        chk("R4 high is inactive", reg_rdata[5], 0);
        cmp_in = 0;
        repeat (3) cycle();
        chk("R2 comparator sets flag", reg_rdata[5], 1);
        // R6: clear written while the source is still active
        wr_reg(8'b1000_0101);
        chk("R6 hw set wins", reg_rdata[5], 1);
        cmp_in = 1;
        repeat (3) cycle();
        wr_reg(8'b0100_0000);

        // R3: pin at active level with enable off
        brk_pin = 1;
        repeat (6) cycle();
        chk("R3 pin ignored", reg_rdata[5], 0);
        brk_pin = 0;
        repeat (3) cycle();

        // random mix
        for (int n = 0; n < 20000; n++) begin
            if ($urandom % 64 == 0) begin
                reg_wr = 1;
                reg_wdata = 8'($urandom);
                if ($urandom % 4 != 0) reg_wdata[5] = 0;
            end
            if ($urandom % 32 == 0) begin
                duty_wr = 1; duty_sel = 2'($urandom); duty_wdata = 12'($urandom);
            end
            if ($urandom % 128 == 0) out_en = 4'($urandom);
            if ($urandom % 200 == 0) brk_pin = ~brk_pin;
            if ($urandom % 200 == 0) cmp_in = ~cmp_in;
            cycle();
            reg_wr = 0; duty_wr = 0;
        end

        done = 1;
        summary();
        $finish;
    end
endmodule